// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Unit

This block holds, for each of eight transmit descriptor rings, a base address and a current descriptor pointer, and keeps each pointer moving as a DMA engine works through the ring. Software programs every ring's base address through a small write port. A registered read port returns both the base and the current pointer of any ring.

The DMA engine names the ring it is serving and reports three kinds of event for it. A successful descriptor close carries a wrap flag. A close without the flag moves the pointer forward by one 8-byte descriptor. A close with the flag sends the pointer back to the ring's base, so the ring length is set by where software places the flag, not by a fixed count. On a frame start the unit saves the pointer as the frame's first descriptor. On an abort after an error it restores that saved address, so the frame can be sent again from its first descriptor.

All addresses are 32 bits and are aligned to 8 bytes. The three low bits are never stored and always read as zero. Pointer arithmetic wraps modulo 2^32. When software writes a base while the ring's transmit enable is low, the same aligned value is also loaded into the ring's pointer, which puts the ring in its start position.

Top module: `txring_ptr_unit`

## Requirements
- R1: After a synchronous reset every ring's base and current pointer read back as 0.
- R2: A base write stores the written value with bits [2:0] forced to zero, whatever those bits held in the write data.
- R3: Bits [2:0] of every current pointer read as zero at all times.
- R4: A close event without the wrap flag on the served ring raises that ring's pointer by 8, modulo 2^32.
- R5: A close event with the wrap flag (dma_close_wrap=1) loads that ring's pointer from its base register.
- R6: A start event saves the served ring's current pointer. A later abort event on that ring restores the pointer to the saved address.
- R7: If a close and an abort are reported in the same cycle for one ring, the abort wins and the pointer takes the saved frame-start address.
- R8: A base write to a ring whose enable bit (ring_en[n], bit n for ring n) is 0 also loads the aligned value into that ring's pointer. When the enable bit is 1, the pointer is left unchanged.
- R9: DMA events change only the ring named by dma_ring. Every other ring's base and pointer keep their values.
- R10: The read outputs show the ring selected by rd_ring one clock after it is presented, and keep their previous value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_en | input | 8 | Per-ring transmit enable, bit n for ring n |
| wr_en | input | 1 | Base register write strobe |
| wr_ring | input | 3 | Ring whose base is written |
| wr_data | input | 32 | Base address write data |
| rd_ring | input | 3 | Ring selected for readback |
| rd_base | output | 32 | Registered base address of the selected ring |
| rd_ptr | output | 32 | Registered current pointer of the selected ring |
| dma_ring | input | 3 | Ring the DMA engine is serving |
| dma_close | input | 1 | Descriptor closed successfully |
| dma_close_wrap | input | 1 | Wrap flag of the closed descriptor |
| dma_start | input | 1 | Frame started at the current descriptor |
| dma_abort | input | 1 | Frame aborted on error |

## Verification
The hardest case to reach from the ports is an abort that arrives after a frame has already moved its pointer forward through several descriptors. It is harder still when a close arrives in the same cycle as the abort. The bench reaches both for every ring. It issues a start, then a run of closes, then the abort, and it checks the readback against an address model computed in the bench. Modulo wrap is reached by writing a base of 0xFFFF_FFF8 to a disabled ring, which loads that value into the pointer, and then closing one descriptor.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef struct packed {
    logic close;
    logic wrap;
    logic start;
    logic abort;
  } dma_evt_t;
endpackage

// File: rtl/txring_base_bank.sv
module txring_base_bank #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int LB = 3,
  localparam int RW = $clog2(N),
  localparam int UW = AW - LB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_ring,
  input  logic [AW-1:0]        wr_data,
  output logic [N-1:0][UW-1:0] base_q
);
  for (genvar i = 0; i < N; i++) begin : g_base
    logic [UW-1:0] b_r;
    always_ff @(posedge clk) begin
      if (rst)
        b_r <= '0;
      else if (wr_en && wr_ring == RW'(i))
        b_r <= wr_data[AW-1:LB];
    end
    assign base_q[i] = b_r;
  end
endmodule

// File: rtl/txring_ptr_engine.sv
module txring_ptr_engine
  import txring_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int LB = 3,
  localparam int RW = $clog2(N),
  localparam int UW = AW - LB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RW-1:0]        dma_ring,
  input  dma_evt_t             evt,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_ring,
  input  logic [AW-1:0]        wr_data,
  input  logic [N-1:0]         ring_en,
  input  logic [N-1:0][UW-1:0] base_q,
  output logic [N-1:0][UW-1:0] ptr_q,
  output logic [N-1:0][UW-1:0] fs_q
);
  localparam logic [UW-1:0] STEP = {{(UW-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < N; i++) begin : g_ring
    logic          hit;
    logic          seed;
    logic [UW-1:0] p_r;
    logic [UW-1:0] f_r;

    assign hit  = (dma_ring == RW'(i));
    assign seed = wr_en && (wr_ring == RW'(i)) && !ring_en[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        p_r <= '0;
        f_r <= '0;
      end else begin
        if (hit && evt.abort)
          p_r <= f_r;
        else if (hit && evt.close)
          p_r <= evt.wrap ? base_q[i] : p_r + STEP;
        else if (seed)
          p_r <= wr_data[AW-1:LB];
        if (hit && evt.start && !evt.abort)
          f_r <= p_r;
      end
    end

    assign ptr_q[i] = p_r;
    assign fs_q[i]  = f_r;
  end
endmodule

// File: rtl/txring_read_port.sv
module txring_read_port #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int LB = 3,
  localparam int RW = $clog2(N),
  localparam int UW = AW - LB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RW-1:0]        rd_ring,
  input  logic [N-1:0][UW-1:0] base_q,
  input  logic [N-1:0][UW-1:0] ptr_q,
  output logic [AW-1:0]        rd_base,
  output logic [AW-1:0]        rd_ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_base <= '0;
      rd_ptr  <= '0;
    end else begin
      rd_base <= {base_q[rd_ring], {LB{1'b0}}};
      rd_ptr  <= {ptr_q[rd_ring], {LB{1'b0}}};
    end
  end
endmodule

// File: rtl/txring_ptr_unit.sv
module txring_ptr_unit
  import txring_pkg::*;
#(
  parameter int NUM_RINGS  = 8,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  localparam int RW = $clog2(NUM_RINGS),
  localparam int UW = ADDR_W - ALIGN_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RINGS-1:0] ring_en,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_ring,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic [RW-1:0]        rd_ring,
  output logic [ADDR_W-1:0]    rd_base,
  output logic [ADDR_W-1:0]    rd_ptr,
  input  logic [RW-1:0]        dma_ring,
  input  logic                 dma_close,
  input  logic                 dma_close_wrap,
  input  logic                 dma_start,
  input  logic                 dma_abort
);
  logic [NUM_RINGS-1:0][UW-1:0] base_q;
  logic [NUM_RINGS-1:0][UW-1:0] ptr_q;
  logic [NUM_RINGS-1:0][UW-1:0] fs_q;
  dma_evt_t                     evt;

  assign evt = '{close: dma_close, wrap: dma_close_wrap,
                 start: dma_start, abort: dma_abort};

  txring_base_bank #(.N(NUM_RINGS), .AW(ADDR_W), .LB(ALIGN_BITS)) u_base (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ring(wr_ring),
    .wr_data(wr_data), .base_q(base_q)
  );

  txring_ptr_engine #(.N(NUM_RINGS), .AW(ADDR_W), .LB(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst(rst), .dma_ring(dma_ring), .evt(evt),
    .wr_en(wr_en), .wr_ring(wr_ring), .wr_data(wr_data),
    .ring_en(ring_en), .base_q(base_q), .ptr_q(ptr_q), .fs_q(fs_q)
  );

  txring_read_port #(.N(NUM_RINGS), .AW(ADDR_W), .LB(ALIGN_BITS)) u_rd (
    .clk(clk), .rst(rst), .rd_ring(rd_ring), .base_q(base_q),
    .ptr_q(ptr_q), .rd_base(rd_base), .rd_ptr(rd_ptr)
  );
endmodule

// File: rtl/txring_ptr_checker.sv
module txring_ptr_checker #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int LB = 3,
  localparam int RW = $clog2(N),
  localparam int UW = AW - LB
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         ring_en,
  input logic                 wr_en,
  input logic [RW-1:0]        wr_ring,
  input logic [AW-1:0]        wr_data,
  input logic [RW-1:0]        dma_ring,
  input logic                 dma_close,
  input logic                 dma_close_wrap,
  input logic                 dma_abort,
  input logic [N-1:0][UW-1:0] base_q,
  input logic [N-1:0][UW-1:0] ptr_q,
  input logic [N-1:0][UW-1:0] fs_q,
  input logic [AW-1:0]        rd_base,
  input logic [AW-1:0]        rd_ptr
);
  localparam logic [UW-1:0] STEP = {{(UW-1){1'b0}}, 1'b1};
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  always_ff @(posedge clk) begin
    if (rst_seen && !rst)
      assert_reset_zero_R1: assert (rd_base == '0 && rd_ptr == '0)
        else $error("read outputs not zero after reset");
  end

  assert_ptr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> rd_ptr[LB-1:0] == '0);

  assert_close_step_R4: assert property (@(posedge clk) disable iff (rst)
    (dma_close && !dma_close_wrap && !dma_abort)
    |=> ptr_q[$past(dma_ring)] == $past(ptr_q[dma_ring]) + STEP);

  assert_close_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_close && dma_close_wrap && !dma_abort)
    |=> ptr_q[$past(dma_ring)] == $past(base_q[dma_ring]));

  assert_abort_rewind_R6: assert property (@(posedge clk) disable iff (rst)
    dma_abort |=> ptr_q[$past(dma_ring)] == $past(fs_q[dma_ring]));

  assert_abort_beats_close_R7: assert property (@(posedge clk) disable iff (rst)
    (dma_abort && dma_close) |=> ptr_q[$past(dma_ring)] == $past(fs_q[dma_ring]));

  assert_seed_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ring_en[wr_ring] &&
     !((dma_close || dma_abort) && dma_ring == wr_ring))
    |=> ptr_q[$past(wr_ring)] == $past(wr_data[AW-1:LB]));
endmodule

bind txring_ptr_unit txring_ptr_checker #(
  .N(NUM_RINGS), .AW(ADDR_W), .LB(ALIGN_BITS)
) u_chk (
  .clk(clk), .rst(rst), .ring_en(ring_en), .wr_en(wr_en),
  .wr_ring(wr_ring), .wr_data(wr_data), .dma_ring(dma_ring),
  .dma_close(dma_close), .dma_close_wrap(dma_close_wrap),
  .dma_abort(dma_abort), .base_q(base_q), .ptr_q(ptr_q), .fs_q(fs_q),
  .rd_base(rd_base), .rd_ptr(rd_ptr)
);

// File: tb/txring_ptr_unit_test.sv
module txring_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  ring_en;
  logic        wr_en;
  logic [2:0]  wr_ring;
  logic [31:0] wr_data;
  logic [2:0]  rd_ring;
  logic [31:0] rd_base;
  logic [31:0] rd_ptr;
  logic [2:0]  dma_ring;
  logic        dma_close, dma_close_wrap, dma_start, dma_abort;

  logic [31:0] mbase [8];
  logic [31:0] mptr  [8];
  logic [31:0] mfs   [8];
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  txring_ptr_unit uut (.*);

  task automatic idle_inputs();
    wr_en = 0; wr_ring = 0; wr_data = 0;
    dma_ring = 0; dma_close = 0; dma_close_wrap = 0;
    dma_start = 0; dma_abort = 0;
  endtask

  task automatic expect32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_ring(int r, string req);
    @(negedge clk);
    rd_ring = 3'(r);
    @(negedge clk);
    expect32(req, $sformatf("base ring %0d", r), rd_base, mbase[r]);
    expect32(req, $sformatf("ptr ring %0d", r), rd_ptr, mptr[r]);
    expect32("R3", "ptr low bits", {29'd0, rd_ptr[2:0]}, 32'd0);
  endtask

  task automatic write_base(int r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_ring = 3'(r); wr_data = d;
    mbase[r] = d & ~32'd7;
    if (!ring_en[r]) mptr[r] = d & ~32'd7;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic dma_event(int r, bit cl, bit wp, bit st, bit ab);
    logic [31:0] old;
    @(negedge clk);
    dma_ring = 3'(r); dma_close = cl; dma_close_wrap = wp;
    dma_start = st; dma_abort = ab;
    old = mptr[r];
    if (ab) mptr[r] = mfs[r];
    else if (cl) mptr[r] = wp ? mbase[r] : old + 32'd8;
    if (st && !ab) mfs[r] = old;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rd_ring = 0; ring_en = 8'h00; rst = 1;
    for (int r = 0; r < 8; r++) begin mbase[r] = 0; mptr[r] = 0; mfs[r] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    for (int r = 0; r < 8; r++) read_ring(r, "R1");

    // R2/R8: seed every disabled ring with an unaligned value
    for (int r = 0; r < 8; r++) write_base(r, 32'h0100_0000 * (r + 1) + 32'h40 * r + 32'(r % 8 | 1));
    for (int r = 0; r < 8; r++) read_ring(r, "R2_R8");

    ring_en = 8'hFF;
    // R8: base write while enabled leaves the pointer alone
    write_base(0, 32'h0BAD_F00D);
    read_ring(0, "R8");

    for (int r = 0; r < 8; r++) begin
      dma_event(r, 0, 0, 1, 0);
      for (int k = 0; k <= r; k++) dma_event(r, 1, 0, 0, 0);
      read_ring(r, "R4");
      read_ring((r + 1) % 8, "R9");
      dma_event(r, 1, 1, 0, 0);
      read_ring(r, "R5");
      dma_event(r, 1, 0, 0, 0);
      dma_event(r, 0, 0, 1, 0);
      dma_event(r, 1, 0, 0, 0);
      dma_event(r, 1, 0, 0, 0);
      dma_event(r, 0, 0, 0, 1);
      read_ring(r, "R6");
      dma_event(r, 1, 0, 0, 0);
      dma_event(r, 1, 0, 0, 1);
      read_ring(r, "R7");
      read_ring((r + 7) % 8, "R9");
    end

    // R4: modulo 2^32 wrap of the pointer
    ring_en[7] = 0;
    write_base(7, 32'hFFFF_FFFF);
    ring_en[7] = 1;
    dma_event(7, 1, 0, 0, 0);
    read_ring(7, "R4");
    expect32("R4", "wrapped ptr", rd_ptr, 32'h0000_0000);

    // R10: selection change visible only after the next edge
    read_ring(3, "R10");
    @(negedge clk);
    rd_ring = 3'd5;
    #1;
    expect32("R10", "ptr before edge", rd_ptr, mptr[3]);
    @(negedge clk);
    expect32("R10", "ptr after edge", rd_ptr, mptr[5]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule